// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Frame Checker

This block divides a serial bit stream by a generator polynomial over GF(2), one bit per accepted cycle, most significant bit first. The polynomial, the register width and the value loaded at the start of a frame are parameters. A frame is marked by a start strobe on its first bit and an end strobe on its last bit. Both strobes travel with a valid-qualified data bit.

In generate mode, every message bit is echoed on the serial output one cycle after it is accepted. After the last message bit, the W-bit remainder follows, MSB first. The outgoing frame is therefore the message followed by its check bits. While the remainder is being sent, the input is not read.

In check mode, a received frame (message plus check bits) is folded into the register and nothing is echoed. One cycle after the last bit, a pass flag reports whether the remainder is zero. The current remainder is always visible on a parallel port.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is high and on the cycle after it, out_valid and pass_valid are 0 and crc_value equals INIT.
- R2: A bit accepted with sof reloads the register with INIT before that bit is folded in, discarding any unfinished frame. mode_check is sampled only on that bit (0 = generate, 1 = check) and holds for the whole frame.
- R3: After the last bit of a frame, crc_value equals the remainder of (bits · x^W) divided by the generator. With INIT = 0 and generator 10011, message 1011001 gives 1010.
- R4: In generate mode, each accepted message bit appears on out_bit with out_valid = 1 on the next cycle.
- R5: In generate mode, the W remainder bits appear MSB first with out_valid = 1 on the W cycles right after the last echoed message bit. For the example in R3 the output is 10110011010.
- R6: During those W cycles, in_valid, sof, eof and in_bit are ignored. No bit is folded in, no bit is echoed and no pass pulse is produced.
- R7: In check mode, out_valid stays 0. pass_valid pulses for one cycle, the cycle after the bit carrying eof.
- R8: pass is 1 exactly when the remainder of the checked frame is zero. An intact generated frame passes, and any single-bit error or error burst of length up to W fails.
- R9: Cycles with in_valid = 0 leave crc_value unchanged, so gaps inside a frame do not change its result.
- R10: A bit carrying both sof and eof forms a complete one-bit frame. A new frame may start on the cycle right after the previous eof.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_check | input | 1 | Mode for the frame, sampled with sof: 0 generate, 1 check |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial data, MSB first |
| sof | input | 1 | Marks the first bit of a frame |
| eof | input | 1 | Marks the last bit of a frame |
| out_valid | output | 1 | Serial output qualifier |
| out_bit | output | 1 | Echoed message bit, then remainder bit |
| crc_value | output | W | Current remainder register |
| pass_valid | output | 1 | One-cycle strobe for the check result |
| pass | output | 1 | 1 when the checked frame leaves a zero remainder |

## Verification
Two things can happen in the same cycle. A check frame's pass pulse can coincide with the first bit of the next frame, which reloads the register. A single bit can also carry both start and end of frame, so the reload and the final verdict come from one bit.

The bench provokes both cases. It sends two check frames back to back with no idle cycle, one intact and one corrupted, and it sends one-bit frames. It judges the results by the ordered list of pass results (1 then 0 for the back-to-back pair) and by crc_value. It also drives start and end strobes during remainder emission and expects them to have no effect.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  typedef enum logic {
    MODE_GEN   = 1'b0,
    MODE_CHECK = 1'b1
  } crc_mode_t;
endpackage

// File: rtl/crc_fold.sv
// One bit of polynomial division folded into a W-bit remainder.
module crc_fold #(
  parameter int           W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011
) (
  input  logic [W-1:0] cur,
  input  logic         bit_in,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1] ^ bit_in;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign nxt[0] = fb & POLY[0];
    end else begin : g_mid
      assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc_emitter.sv
// Holds a remainder and releases it MSB first, one bit per cycle.
module crc_emitter #(
  parameter int W  = 4,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         bit_out
);
  logic [W-1:0]  sr_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sr_q   <= load_val;
      left_q <= CW'(W);
    end else if (left_q != '0) begin
      sr_q   <= {sr_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign busy    = (left_q != '0);
  assign bit_out = sr_q[W-1];
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int           W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_check,
  input  logic         in_valid,
  input  logic         in_bit,
  input  logic         sof,
  input  logic         eof,
  output logic         out_valid,
  output logic         out_bit,
  output logic [W-1:0] crc_value,
  output logic         pass_valid,
  output logic         pass
);
  import crc_serial_pkg::*;

  logic [W-1:0] crc_q;
  logic [W-1:0] base;
  logic [W-1:0] nxt;
  crc_mode_t    mode_q;
  crc_mode_t    mode_eff;
  logic         busy;
  logic         emit_bit;
  logic         accept;
  logic         load;

  assign accept   = in_valid && !busy;
  assign base     = (accept && sof) ? INIT : crc_q;
  assign mode_eff = sof ? crc_mode_t'(mode_check) : mode_q;
  assign load     = accept && eof && (mode_eff == MODE_GEN);

  crc_fold #(.W(W), .POLY(POLY)) u_fold (
    .cur    (base),
    .bit_in (in_bit),
    .nxt    (nxt)
  );

  crc_emitter #(.W(W)) u_emit (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (nxt),
    .busy     (busy),
    .bit_out  (emit_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q      <= INIT;
      mode_q     <= MODE_GEN;
      out_valid  <= 1'b0;
      out_bit    <= 1'b0;
      pass_valid <= 1'b0;
      pass       <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      pass_valid <= 1'b0;
      if (accept) begin
        crc_q <= nxt;
        if (sof) mode_q <= crc_mode_t'(mode_check);
        if (mode_eff == MODE_GEN) begin
          out_valid <= 1'b1;
          out_bit   <= in_bit;
        end else if (eof) begin
          pass_valid <= 1'b1;
          pass       <= (nxt == '0);
        end
      end else if (busy) begin
        out_valid <= 1'b1;
        out_bit   <= emit_bit;
      end
    end
  end

  assign crc_value = crc_q;
endmodule

// File: rtl/crc_serial_unit_props.sv
module crc_serial_unit_props #(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         eof,
  input logic         busy,
  input logic         out_valid,
  input logic [W-1:0] crc_value,
  input logic         pass_valid
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_quiet_r1: assert (!out_valid && !pass_valid && crc_value == INIT)
        else $error("outputs not quiet after reset");
    end
  end

  p_out_cause_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid || busy));

  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(crc_value));

  p_pass_cause_r7: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> $past(in_valid && eof && !busy));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && pass_valid));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(crc_value));
endmodule

bind crc_serial_unit crc_serial_unit_props #(.W(W), .INIT(INIT)) u_props (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .eof        (eof),
  .busy       (busy),
  .out_valid  (out_valid),
  .crc_value  (crc_value),
  .pass_valid (pass_valid)
);

// File: tb/crc_serial_unit_bench.sv
module crc_serial_unit_bench;
  localparam int           W      = 4;
  localparam logic [W-1:0] POLY   = 4'b0011;
  localparam logic [W-1:0] INIT   = 4'b0000;
  localparam int           T_CLK  = 10;

  logic clk = 1'b0;
  logic rst, mode_check, in_valid, in_bit, sof, eof;
  logic out_valid, out_bit, pass_valid, pass;
  logic [W-1:0] crc_value;

  always #(T_CLK/2) clk = ~clk;

  crc_serial_unit #(.W(W), .POLY(POLY), .INIT(INIT)) u_crc_serial_unit (
    .clk(clk), .rst(rst), .mode_check(mode_check), .in_valid(in_valid),
    .in_bit(in_bit), .sof(sof), .eof(eof), .out_valid(out_valid),
    .out_bit(out_bit), .crc_value(crc_value), .pass_valid(pass_valid),
    .pass(pass)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic fbuf [0:63];
  logic sofb [0:63];
  logic eofb [0:63];
  logic cap  [0:63];
  logic plog [0:7];
  int   cap_n  = 0;
  int   pass_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin cap[cap_n] = out_bit; cap_n++; end
    if (pass_valid && pass_n < 8) begin plog[pass_n] = pass; pass_n++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_rem(input int len);
    logic [W-1:0] r;
    logic top, b;
    r = '0;
    for (int i = 0; i < len + W; i++) begin
      top = r[W-1];
      b   = (i < len) ? fbuf[i] : 1'b0;
      r   = {r[W-2:0], b};
      if (top) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic set_frame(input int len);
    for (int i = 0; i < 64; i++) begin sofb[i] = 0; eofb[i] = 0; end
    sofb[0] = 1; eofb[len-1] = 1;
  endtask

  task automatic run_stream(input int len, input bit mode, input int gap, input bit junk);
    cap_n = 0; pass_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_bit = fbuf[i]; sof = sofb[i]; eof = eofb[i];
      mode_check = sofb[i] ? mode : ~mode;
      if (gap > 0 && i != len - 1) begin
        repeat (gap) begin
          @(negedge clk);
          in_valid = 0; sof = 0; eof = 0; in_bit = ~in_bit;
        end
      end
    end
    if (junk) begin
      repeat (W) begin
        @(negedge clk);
        in_valid = 1; sof = 1; eof = 1; in_bit = 1; mode_check = 1;
      end
    end
    @(negedge clk);
    in_valid = 0; sof = 0; eof = 0; in_bit = 0;
    repeat (W + 3) @(negedge clk);
  endtask

  task automatic gen_msg(input logic [6:0] msg, input int gap, input bit junk,
                         output logic [W-1:0] rem);
    logic [10:0] got;
    for (int i = 0; i < 7; i++) fbuf[i] = msg[6-i];
    set_frame(7);
    run_stream(7, 1'b0, gap, junk);
    rem = model_rem(7);
    got = '0;
    for (int i = 0; i < cap_n && i < 11; i++) got = {got[9:0], cap[i]};
    chk(crc_value == rem, "R3 remainder", crc_value, rem);
    chk(got[10:4] == msg, "R4 echo", got[10:4], msg);
    chk(got[3:0] == rem, "R5 appended bits", got[3:0], rem);
    chk(cap_n == 11 && pass_n == 0, "R6 emission length/no pulse", cap_n, 11);
  endtask

  task automatic check_frame(input logic [10:0] fr, input bit exp_pass, input string req);
    for (int i = 0; i < 11; i++) fbuf[i] = fr[10-i];
    set_frame(11);
    run_stream(11, 1'b1, 0, 0);
    chk(pass_n == 1 && cap_n == 0, "R7 one pulse, no output", pass_n, 1);
    chk(pass_n > 0 && plog[0] == exp_pass, req, pass_n > 0 ? int'(plog[0]) : -1, exp_pass);
  endtask

  initial begin
    logic [W-1:0] rem;
    logic [10:0] fr, bad;
    rst = 1; mode_check = 0; in_valid = 0; in_bit = 0; sof = 0; eof = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && pass_valid == 0, "R1 reset outputs", out_valid, 0);
    chk(crc_value == INIT, "R1 reset value", crc_value, INIT);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && pass_valid == 0 && crc_value == INIT, "R1 after reset", crc_value, INIT);

    gen_msg(7'b1011001, 0, 0, rem);
    chk(rem == 4'b1010, "R3 known vector", rem, 4'b1010);
    check_frame(11'b10110011010, 1, "R8 known frame passes");
    chk(crc_value == 0, "R3 check remainder zero", crc_value, 0);

    gen_msg(7'b1011001, 2, 0, rem);
    chk(rem == 4'b1010, "R9 gaps do not alter result", rem, 4'b1010);

    for (int i = 0; i < 3; i++) fbuf[i] = 1;
    for (int i = 0; i < 64; i++) begin sofb[i] = 0; eofb[i] = 0; end
    sofb[0] = 1;
    run_stream(3, 1'b1, 0, 0);
    gen_msg(7'b1011001, 0, 0, rem);
    chk(crc_value == 4'b1010, "R2 sof reload and mode latch", crc_value, 4'b1010);

    for (int m = 0; m < 128; m++) begin
      gen_msg(7'(m), 0, 1, rem);
      fr = {7'(m), rem};
      check_frame(fr, 1, "R8 intact frame");
      if (m % 4 == 1) begin
        for (int p = 0; p < 11; p++) begin
          bad = fr ^ (11'd1 << p);
          check_frame(bad, 0, "R8 single-bit error");
        end
        for (int L = 2; L <= W; L++) begin
          for (int s = 0; s + L <= 11; s++) begin
            logic [10:0] e;
            e = '0;
            e[s] = 1; e[s+L-1] = 1;
            for (int j = 1; j < L - 1; j++) e[s+j] = m[j % 7];
            check_frame(fr ^ e, 0, "R8 burst error");
          end
        end
      end
    end

    fbuf[0] = 0; set_frame(1); run_stream(1, 1'b1, 0, 0);
    chk(pass_n == 1 && plog[0] == 1 && crc_value == 0, "R10 one-bit frame 0", crc_value, 0);
    fbuf[0] = 1; set_frame(1); run_stream(1, 1'b1, 0, 0);
    chk(pass_n == 1 && plog[0] == 0, "R10 one-bit frame 1 pass", plog[0], 0);
    chk(crc_value == POLY, "R10 one-bit frame 1 value", crc_value, POLY);

    fr = 11'b10110011010;
    bad = fr ^ 11'b00000100000;
    for (int i = 0; i < 11; i++) begin fbuf[i] = fr[10-i]; fbuf[11+i] = bad[10-i]; end
    for (int i = 0; i < 64; i++) begin sofb[i] = 0; eofb[i] = 0; end
    sofb[0] = 1; eofb[10] = 1; sofb[11] = 1; eofb[21] = 1;
    run_stream(22, 1'b1, 0, 0);
    chk(pass_n == 2, "R10 back-to-back pulse count", pass_n, 2);
    chk(plog[0] == 1 && plog[1] == 0, "R10 back-to-back verdicts", {plog[0], plog[1]}, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule